// File: doc/BRIEF.md
# Dual-Bank Calendar Configuration Register File

This block is the register file for a status-channel calendar that keeps two banks. Each bank has a multiplier, a length and a calendar RAM. Software reaches both RAMs through one shared indirect address word and a data word per bank. The calendar sequencer reads the RAMs through two read ports of its own. The block shows which bank is active. A bank switch can be requested, and it is applied at the next status frame boundary, so the swap costs no status frames.

The block also shows the sync and disabled state of the status machine. It drives a reset-frame request to that machine: a register bit ORed with an external pin. When the request is present at a frame boundary, the block forces sync low and disabled high until a later boundary finds the request gone. Writes to a bank are blocked while that bank may be in use.

Top module: `calbank_csr`

## Requirements
- R1: A read of word 0 returns the block identifier in bits 15:13 and the identification code in bits 12:0, both taken from parameters.
- R2: Every bus read makes `bus_rvalid` high for one cycle, exactly two cycles after the cycle in which `bus_rd` was high. `bus_rdata` carries the result in that cycle.
- R3: Bit 1 of word 1 is the reset-frame bit and resets to 1. Output `rsfrm_o` is that bit ORed with `ext_rsfrm`.
- R4: On each `frm_end` cycle, the force state takes the value of `rsfrm_o`, and it resets to forced. While forced, `sync_o` is 0 and `disabled_o` is 1. Otherwise they follow `sm_sync` and `sm_disabled`.
- R5: Word 1 reads bit 0 as the switch enable, bit 1 as the reset-frame bit, bit 2 as a pending switch request, bit 3 as the active bank, bit 4 as `sync_o` and bit 5 as `disabled_o`. All other bits read 0.
- R6: A write to word 1 with bits 0 and 2 both set raises the pending request. A write with bit 0 clear drops it. On a `frm_end` cycle with the request pending, the active bank toggles and the request clears. `cal_sel` is 2'b01 for bank 0 and 2'b10 for bank 1, and `cal_sel_en` equals the switch enable.
- R7: The bank 0 words are the multiplier (word 2, 8 bits), the length (word 4, 10 bits) and the RAM data (word 7). A write to any of them takes effect only when `disabled_o` is 1 or the active bank is 1.
- R8: The bank 1 words are words 3, 5 and 8. A write to any of them takes effect only when the switch enable is 1 and either `disabled_o` is 1 or the active bank is 0.
- R9: Word 6 holds a 10-bit RAM address. A write to word 7 or word 8 stores the low 8 data bits into that bank's RAM at this address. A read of word 7 or word 8 returns that RAM's content at the address.
- R10: Words 9 to 15 read 0 and ignore writes. Register bits above each field's width read 0.
- R11: `seq_data0` and `seq_data1` return the bank 0 and bank 1 RAM contents at `seq_addr0` and `seq_addr1` one cycle after the address is presented.
- R12: While the switch enable is 0, words 3, 5 and 8 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| ext_rsfrm | input | 1 | External reset-frame request |
| frm_end | input | 1 | Status frame boundary pulse |
| sm_sync | input | 1 | Sync state from the status machine |
| sm_disabled | input | 1 | Disabled state from the status machine |
| rsfrm_o | output | 1 | Effective reset-frame request |
| sync_o | output | 1 | Sync after forcing |
| disabled_o | output | 1 | Disabled after forcing |
| cal_sel | output | 2 | Calendar select word |
| cal_sel_en | output | 1 | Select word carried in frames |
| active_bank | output | 1 | Active bank |
| mult0 | output | 8 | Bank 0 multiplier |
| mult1 | output | 8 | Bank 1 multiplier |
| len0 | output | 10 | Bank 0 length |
| len1 | output | 10 | Bank 1 length |
| seq_addr0 | input | 10 | Sequencer read address, bank 0 |
| seq_addr1 | input | 10 | Sequencer read address, bank 1 |
| seq_data0 | output | 8 | Sequencer read data, bank 0 |
| seq_data1 | output | 8 | Sequencer read data, bank 1 |

## Verification
The assertions check four things on every cycle: the fixed two-cycle read latency, the forcing that follows a boundary seen with the reset-frame request up, that the active bank changes only on a boundary, and that a guarded multiplier write is blocked. Other behaviour can only be shown by the bench's scenarios, which it compares against a behavioural model: that an indirect read returns what an earlier write stored, that the bank 1 words fall silent when the switch enable is cleared, that reserved words stay zero, and that a write allowed by a forced disable lands in the running bank.

// File: rtl/calbank_csr.sv
module calbank_csr #(
  parameter int RAM_AW = 10,
  parameter int CAL_W  = 8,
  parameter int MULT_W = 8,
  parameter int LEN_W  = 10,
  parameter logic [12:0] ID_CODE = 13'h0A5C,
  parameter logic [2:0]  BLK_ID  = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              ext_rsfrm,
  input  logic              frm_end,
  input  logic              sm_sync,
  input  logic              sm_disabled,
  output logic              rsfrm_o,
  output logic              sync_o,
  output logic              disabled_o,
  output logic [1:0]        cal_sel,
  output logic              cal_sel_en,
  output logic              active_bank,
  output logic [MULT_W-1:0] mult0,
  output logic [MULT_W-1:0] mult1,
  output logic [LEN_W-1:0]  len0,
  output logic [LEN_W-1:0]  len1,
  input  logic [RAM_AW-1:0] seq_addr0,
  input  logic [RAM_AW-1:0] seq_addr1,
  output logic [CAL_W-1:0]  seq_data0,
  output logic [CAL_W-1:0]  seq_data1
);
  localparam int DEPTH = 1 << RAM_AW;

  logic              sw_en, rsf_q, pend_q, act_q, hold_q;
  logic [RAM_AW-1:0] ram_adr;
  logic [CAL_W-1:0]  ram0 [DEPTH];
  logic [CAL_W-1:0]  ram1 [DEPTH];
  logic [CAL_W-1:0]  rq0, rq1;
  logic              p1_v;
  logic [3:0]        p1_a;
  logic              b0_ok, b1_ok;
  logic [15:0]       rd_mux;

  assign rsfrm_o     = rsf_q | ext_rsfrm;
  assign sync_o      = sm_sync & ~hold_q;
  assign disabled_o  = sm_disabled | hold_q;
  assign active_bank = act_q;
  assign cal_sel     = act_q ? 2'b10 : 2'b01;
  assign cal_sel_en  = sw_en;
  assign b0_ok       = disabled_o | act_q;
  assign b1_ok       = sw_en & (disabled_o | ~act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en  <= 1'b0;
      rsf_q  <= 1'b1;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      hold_q <= 1'b1;
      mult0  <= '0;
      mult1  <= '0;
      len0   <= '0;
      len1   <= '0;
      ram_adr <= '0;
    end else begin
      if (frm_end) begin
        hold_q <= rsfrm_o;
        if (pend_q) begin
          act_q  <= ~act_q;
          pend_q <= 1'b0;
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          4'd1: begin
            sw_en <= bus_wdata[0];
            rsf_q <= bus_wdata[1];
            if (bus_wdata[0] && bus_wdata[2]) pend_q <= 1'b1;
            else if (!bus_wdata[0])           pend_q <= 1'b0;
          end
          4'd2: if (b0_ok) mult0 <= bus_wdata[MULT_W-1:0];
          4'd3: if (b1_ok) mult1 <= bus_wdata[MULT_W-1:0];
          4'd4: if (b0_ok) len0  <= bus_wdata[LEN_W-1:0];
          4'd5: if (b1_ok) len1  <= bus_wdata[LEN_W-1:0];
          4'd6: ram_adr <= bus_wdata[RAM_AW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && bus_addr == 4'd7 && b0_ok) ram0[ram_adr] <= bus_wdata[CAL_W-1:0];
    if (bus_wr && bus_addr == 4'd8 && b1_ok) ram1[ram_adr] <= bus_wdata[CAL_W-1:0];
    if (bus_rd) begin
      rq0 <= ram0[ram_adr];
      rq1 <= ram1[ram_adr];
    end
    seq_data0 <= ram0[seq_addr0];
    seq_data1 <= ram1[seq_addr1];
  end

  always_comb begin
    rd_mux = '0;
    case (p1_a)
      4'd0: rd_mux = {BLK_ID, ID_CODE};
      4'd1: rd_mux[5:0] = {disabled_o, sync_o, act_q, pend_q, rsf_q, sw_en};
      4'd2: rd_mux[MULT_W-1:0] = mult0;
      4'd3: if (sw_en) rd_mux[MULT_W-1:0] = mult1;
      4'd4: rd_mux[LEN_W-1:0] = len0;
      4'd5: if (sw_en) rd_mux[LEN_W-1:0] = len1;
      4'd6: rd_mux[RAM_AW-1:0] = ram_adr;
      4'd7: rd_mux[CAL_W-1:0] = rq0;
      4'd8: if (sw_en) rd_mux[CAL_W-1:0] = rq1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_v       <= 1'b0;
      p1_a       <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      p1_v       <= bus_rd;
      p1_a       <= bus_addr;
      bus_rvalid <= p1_v;
      if (p1_v) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/calbank_csr_chk.sv
module calbank_csr_chk #(
  parameter int MULT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [3:0]        bus_addr,
  input logic              bus_rvalid,
  input logic              frm_end,
  input logic              rsfrm_o,
  input logic              sync_o,
  input logic              disabled_o,
  input logic              active_bank,
  input logic [MULT_W-1:0] mult0,
  input logic [MULT_W-1:0] mult1
);
  // R2
  rvalid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid == $past(bus_rd, 2));

  // R4
  hold_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frm_end && rsfrm_o) |-> (!sync_o && disabled_o));

  // R6
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_bank != $past(active_bank)) |-> $past(frm_end));

  // R7
  bank0_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd2 && !disabled_o && !active_bank) |=> $stable(mult0));

  // R8
  bank1_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd3 && !disabled_o && active_bank) |=> $stable(mult1));
endmodule

bind calbank_csr calbank_csr_chk #(.MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .frm_end(frm_end), .rsfrm_o(rsfrm_o), .sync_o(sync_o),
  .disabled_o(disabled_o), .active_bank(active_bank), .mult0(mult0), .mult1(mult1)
);

// File: tb/calbank_csr_tb_top.sv
module calbank_csr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] IDC = 13'h0A5C;
  localparam logic [2:0]  BID = 3'd5;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid, ext_rsfrm = 0, frm_end = 0, sm_sync = 0, sm_disabled = 0;
  logic rsfrm_o, sync_o, disabled_o, cal_sel_en, active_bank;
  logic [1:0] cal_sel;
  logic [7:0] mult0, mult1, seq_data0, seq_data1;
  logic [9:0] len0, len1, seq_addr0 = 0, seq_addr1 = 0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calbank_csr #(.ID_CODE(IDC), .BLK_ID(BID)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ext_rsfrm(ext_rsfrm), .frm_end(frm_end), .sm_sync(sm_sync), .sm_disabled(sm_disabled),
    .rsfrm_o(rsfrm_o), .sync_o(sync_o), .disabled_o(disabled_o), .cal_sel(cal_sel),
    .cal_sel_en(cal_sel_en), .active_bank(active_bank), .mult0(mult0), .mult1(mult1),
    .len0(len0), .len1(len1), .seq_addr0(seq_addr0), .seq_addr1(seq_addr1),
    .seq_data0(seq_data0), .seq_data1(seq_data1));

  // behavioural reference model
  bit m_en, m_rsf, m_pend, m_act, m_hold, m_p1_v, m_rv, m_s0k, m_s1k;
  int m_mult0, m_mult1, m_len0, m_len1, m_adr, m_p1_a, m_p1_r0, m_p1_r1, m_rd, m_s0, m_s1;
  int m_ram0 [int];
  int m_ram1 [int];

  function automatic int model_word(int a);
    case (a)
      0: return {BID, IDC};
      1: return {m_hold | sm_disabled, sm_sync & !m_hold, m_act, m_pend, m_rsf, m_en};
      2: return m_mult0;
      3: return m_en ? m_mult1 : 0;
      4: return m_len0;
      5: return m_en ? m_len1 : 0;
      6: return m_adr;
      7: return m_p1_r0;
      8: return m_en ? m_p1_r1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string word_tag(int a);
    case (a)
      0: return "R1";
      1: return "R5";
      2, 4: return "R7";
      3, 5: return m_en ? "R8" : "R12";
      6, 7: return "R9";
      8: return m_en ? "R9" : "R12";
      default: return "R10";
    endcase
  endfunction

  string m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rsf = 1; m_pend = 0; m_act = 0; m_hold = 1;
      m_mult0 = 0; m_mult1 = 0; m_len0 = 0; m_len1 = 0; m_adr = 0;
      m_p1_v = 0; m_rv = 0; m_rd = 0; m_s0k = 0; m_s1k = 0;
    end else begin
      bit dis, b0, b1, eff;
      dis = sm_disabled | m_hold;
      b0 = dis | m_act;
      b1 = m_en & (dis | !m_act);
      eff = m_rsf | ext_rsfrm;
      m_rv = m_p1_v;
      if (m_p1_v) begin m_rd = model_word(m_p1_a); m_tag = word_tag(m_p1_a); end
      m_p1_v = bus_rd;
      if (bus_rd) begin
        m_p1_a  = bus_addr;
        m_p1_r0 = m_ram0.exists(m_adr) ? m_ram0[m_adr] : 0;
        m_p1_r1 = m_ram1.exists(m_adr) ? m_ram1[m_adr] : 0;
      end
      m_s0k = m_ram0.exists(int'(seq_addr0)); if (m_s0k) m_s0 = m_ram0[int'(seq_addr0)];
      m_s1k = m_ram1.exists(int'(seq_addr1)); if (m_s1k) m_s1 = m_ram1[int'(seq_addr1)];
      if (frm_end) begin
        m_hold = eff;
        if (m_pend) begin m_act = !m_act; m_pend = 0; end
      end
      if (bus_wr) begin
        case (bus_addr)
          1: begin
            m_en = bus_wdata[0]; m_rsf = bus_wdata[1];
            if (bus_wdata[0] && bus_wdata[2]) m_pend = 1;
            else if (!bus_wdata[0]) m_pend = 0;
          end
          2: if (b0) m_mult0 = bus_wdata & 16'hFF;
          3: if (b1) m_mult1 = bus_wdata & 16'hFF;
          4: if (b0) m_len0 = bus_wdata & 16'h3FF;
          5: if (b1) m_len1 = bus_wdata & 16'h3FF;
          6: m_adr = bus_wdata & 16'h3FF;
          7: if (b0) m_ram0[m_adr] = bus_wdata & 16'hFF;
          8: if (b1) m_ram1[m_adr] = bus_wdata & 16'hFF;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "rvalid", int'(bus_rvalid), int'(m_rv));
      if (m_rv) chk(m_tag, "rdata", int'(bus_rdata), m_rd);
      chk("R3", "rsfrm_o", int'(rsfrm_o), int'(m_rsf | ext_rsfrm));
      chk("R4", "sync/disabled", int'({sync_o, disabled_o}),
          int'({sm_sync & !m_hold, sm_disabled | m_hold}));
      chk("R6", "bank/sel/en", int'({active_bank, cal_sel, cal_sel_en}),
          int'({m_act, m_act ? 2'b10 : 2'b01, m_en}));
      chk("R7", "bank0 regs", int'({mult0, len0}), (m_mult0 << 10) | m_len0);
      chk("R8", "bank1 regs", int'({mult1, len1}), (m_mult1 << 10) | m_len1);
      if (m_s0k) chk("R11", "seq_data0", int'(seq_data0), m_s0);
      if (m_s1k) chk("R11", "seq_data1", int'(seq_data1), m_s1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = 16'(d);
    step();
    bus_wr = 0;
  endtask

  task automatic rd(int a);
    bus_rd = 1; bus_addr = 4'(a);
    step();
    bus_rd = 0;
    step(3);
  endtask

  task automatic fe();
    frm_end = 1; step(); frm_end = 0; step();
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    rd(0);                      // R1
    rd(1);                      // R5, R3 reset value
    sm_sync = 1; sm_disabled = 0;
    step();
    wr(2, 16'h01AB);            // R10 upper bits dropped
    wr(4, 16'hFFFF);
    wr(1, 16'h0001);
    step(2);                    // R4 still forced before boundary
    fe();
    rd(1);
    wr(2, 16'h0055);            // R7 blocked
    rd(2);
    wr(3, 16'h0066);            // R8 allowed
    wr(5, 16'h0123);
    rd(3); rd(5);
    wr(6, 16'h03FF);            // R9
    wr(8, 16'h005A);
    wr(7, 16'h0011);            // R7 blocked RAM write
    rd(8); rd(6);
    wr(6, 5);
    wr(8, 16'h00C3);
    seq_addr1 = 10'd5;          // R11
    step(2);
    wr(1, 16'h0005);            // R6 request
    rd(1);
    step(2);
    fe();
    rd(1);
    wr(2, 16'h0077);            // R7 allowed on bank 1 active
    wr(3, 16'h0099);            // R8 blocked
    wr(6, 5);
    wr(7, 16'h003C);
    rd(7); rd(2); rd(3);
    seq_addr0 = 10'd5;
    step(2);
    ext_rsfrm = 1;              // R3, R4
    step(2);
    fe();
    wr(3, 16'h0044);            // R8 allowed while disabled
    rd(3);
    ext_rsfrm = 0;
    step();
    fe();
    wr(1, 16'h0000);            // R12
    rd(3); rd(5); rd(8);
    wr(3, 16'h0012);
    wr(1, 16'h0001);
    rd(3);
    for (int a = 9; a < 16; a++) rd(a);   // R10
    wr(12, 16'hFFFF);
    rd(12);
    wr(1, 16'h0002);            // R3 register bit alone
    step(2);
    fe();
    rd(1);
    step(3);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule